// File: doc/BRIEF.md
# Circular Load Queue with Bulk Commit and Tail Squash

This block tracks in-flight loads of an out-of-order core in a ring of slots. Dispatch places each load at the tail in program order, tagged with its sequence number. The block also stores where the store queue stood at that moment: the store-queue tail index, or "no older store" when the store queue was empty. Commit retires loads from the head. A branch or ordering squash discards loads from the tail.

Commit and squash are both bulk operations. A single request carries a sequence-number bound. The block then walks the ring one entry per clock and raises `busy_o` until it reaches the end. The ring has one slot more than its capacity, so a full ring and an empty ring never have equal pointers. The block reports how many loads can still be dispatched, taking both queues into account. It also keeps a flag for a blocked load, which a squash clears when the squash reaches that load.

Top module: `load_queue`

## Requirements
- R1: After reset the queue is empty (`count_o`=0, `head_valid_o`=0), `busy_o`=0, `blk_o`=0, `alloc_ready_o`=1 when no command is presented, and the first allocation goes to slot 0.
- R2: An allocation is accepted when `alloc_valid_i` and `alloc_ready_o` are both high. It writes slot `alloc_idx_o` and raises `count_o` by one. The ring holds at most LQ_CAP entries. At LQ_CAP, `alloc_ready_o` is 0 and an offered allocation leaves `count_o` unchanged.
- R3: Each entry records the store-queue position. If `sq_used_i`=0 it records invalid (`head_sq_vld_o`=0). Otherwise it records `head_sq_vld_o`=1 and `head_sq_idx_o`=`sq_tail_i` as sampled at allocation. Both are visible when the entry is at the head.
- R4: A commit request with bound B removes head entries, one per clock, while the queue is non-empty and the head sequence number is ≤ B (unsigned). Removing k entries keeps `busy_o` high for k+1 samples after the request edge.
- R5: A squash request with bound B removes entries at the tail, one per clock, while the queue is non-empty and the youngest sequence number is > B. It stops at the first entry that is not younger or when the queue is empty. `busy_o` stays high for k+1 samples, where k is the number of entries removed.
- R6: While `busy_o` is high, allocation is refused and new commit and squash requests are ignored. A squash and a commit presented in the same idle cycle start the squash only. `alloc_ready_o` is 0 in any cycle that presents a command.
- R7: `blk_set_i` sets `blk_o` and records `blk_seq_i`. An accepted squash whose bound is strictly less than the recorded sequence number clears `blk_o`. Any other squash leaves it set. A set in the same cycle wins.
- R8: `free_o` = min(LQ_CAP+1−`count_o`, SQ_CAP+1−`sq_used_i`) − 1, floored at 0.
- R9: Slot indices advance from LQ_CAP to 0 on allocation and step back from 0 to LQ_CAP on squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Dispatch offers a load |
| alloc_seq_i | input | SEQ_W | Sequence number of the offered load |
| alloc_ready_o | output | 1 | Allocation can be accepted this cycle |
| alloc_idx_o | output | $clog2(LQ_CAP+1) | Slot the next load will occupy |
| sq_used_i | input | $clog2(SQ_CAP+2) | Occupied store-queue entries |
| sq_tail_i | input | $clog2(SQ_CAP+1) | Current store-queue tail index |
| commit_valid_i | input | 1 | Start bulk commit |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_valid_i | input | 1 | Start tail squash |
| squash_seq_i | input | SEQ_W | Squash bound; younger loads are dropped |
| busy_o | output | 1 | Commit or squash walk in progress |
| blk_set_i | input | 1 | Mark a load as blocked |
| blk_seq_i | input | SEQ_W | Sequence number of the blocked load |
| blk_o | output | 1 | Blocked-load condition pending |
| head_valid_o | output | 1 | Queue non-empty |
| head_seq_o | output | SEQ_W | Sequence number of the oldest load |
| head_sq_vld_o | output | 1 | Oldest load has a recorded store index |
| head_sq_idx_o | output | $clog2(SQ_CAP+1) | Recorded store index of the oldest load |
| count_o | output | $clog2(LQ_CAP+2) | Occupied entries |
| free_o | output | $clog2(LQ_CAP+2) | Loads that can still be dispatched |

## Verification
Allocation changes `count_o` and `alloc_idx_o` at the accepting edge. The bench samples these 1 ns after that edge, and it reads `alloc_idx_o` before the edge because that value is already valid. A commit or squash of k entries keeps `busy_o` high for k+1 samples: one sample for the request edge, one per removed entry, and the last one for the edge that finds the stopping entry. The bench counts busy samples after each request and compares the total with k+1 before it reads `count_o`, the head fields or `alloc_idx_o`. `free_o` and `alloc_ready_o` are combinational, so the bench checks them in the same cycle that its inputs change.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_COMMIT = 2'd1,
    OP_SQUASH = 2'd2
  } lq_op_e;

  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned wrap_dec(int unsigned p, int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction
endpackage

// File: rtl/lq_ptr.sv
module lq_ptr
  import lq_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (inc_i) ptr_q <= IW'(wrap_inc(32'(ptr_q), DEPTH));
    else if (dec_i) ptr_q <= IW'(wrap_dec(32'(ptr_q), DEPTH));
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lq_slots.sv
module lq_slots #(
  parameter int DEPTH = 7,
  parameter int SEQ_W = 16,
  parameter int SQI_W = 3,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    waddr_i,
  input  logic [SEQ_W-1:0] wseq_i,
  input  logic             wsq_vld_i,
  input  logic [SQI_W-1:0] wsq_idx_i,
  input  logic [IW-1:0]    raddr_h_i,
  input  logic [IW-1:0]    raddr_t_i,
  output logic [SEQ_W-1:0] seq_h_o,
  output logic             sq_vld_h_o,
  output logic [SQI_W-1:0] sq_idx_h_o,
  output logic [SEQ_W-1:0] seq_t_o
);
  logic [SEQ_W-1:0] seq_q    [DEPTH];
  logic             sq_vld_q [DEPTH];
  logic [SQI_W-1:0] sq_idx_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = we_i && (waddr_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seq_q[g]    <= '0;
        sq_vld_q[g] <= 1'b0;
        sq_idx_q[g] <= '0;
      end else if (hit) begin
        seq_q[g]    <= wseq_i;
        sq_vld_q[g] <= wsq_vld_i;
        sq_idx_q[g] <= wsq_idx_i;
      end
    end
  end

  assign seq_h_o    = seq_q[raddr_h_i];
  assign sq_vld_h_o = sq_vld_q[raddr_h_i];
  assign sq_idx_h_o = sq_idx_q[raddr_h_i];
  assign seq_t_o    = seq_q[raddr_t_i];
endmodule

// File: rtl/lq_free.sv
module lq_free #(
  parameter int LQ_CAP = 6,
  parameter int SQ_CAP = 4,
  parameter int CW     = $clog2(LQ_CAP+2),
  parameter int SQCW   = $clog2(SQ_CAP+2)
) (
  input  logic [CW-1:0]   used_i,
  input  logic [SQCW-1:0] sq_used_i,
  output logic [CW-1:0]   free_o
);
  int lq_room, sq_room, room;

  always_comb begin
    lq_room = LQ_CAP + 1 - int'(used_i);
    sq_room = SQ_CAP + 1 - int'(sq_used_i);
    room    = (lq_room < sq_room) ? lq_room : sq_room;
    if (room < 1) room = 1;  // out-of-range store count clamps to zero
    free_o  = CW'(room - 1);
  end
endmodule

// File: rtl/load_queue.sv
module load_queue
  import lq_pkg::*;
#(
  parameter int LQ_CAP = 6,
  parameter int SQ_CAP = 4,
  parameter int SEQ_W  = 16,
  parameter int DEPTH  = LQ_CAP + 1,
  parameter int IW     = $clog2(DEPTH),
  parameter int CW     = $clog2(LQ_CAP + 2),
  parameter int SQCW   = $clog2(SQ_CAP + 2),
  parameter int SQIW   = $clog2(SQ_CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  output logic             alloc_ready_o,
  output logic [IW-1:0]    alloc_idx_o,
  input  logic [SQCW-1:0]  sq_used_i,
  input  logic [SQIW-1:0]  sq_tail_i,
  input  logic             commit_valid_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             busy_o,
  input  logic             blk_set_i,
  input  logic [SEQ_W-1:0] blk_seq_i,
  output logic             blk_o,
  output logic             head_valid_o,
  output logic [SEQ_W-1:0] head_seq_o,
  output logic             head_sq_vld_o,
  output logic [SQIW-1:0]  head_sq_idx_o,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    free_o
);
  lq_op_e           op_q;
  logic [SEQ_W-1:0] bound_q;
  logic [CW-1:0]    used_q;
  logic             blk_q;
  logic [SEQ_W-1:0] blk_seq_q;

  logic [IW-1:0]    head, tail, tail_nxt, tail_prv;
  logic [SEQ_W-1:0] seq_head, seq_last;
  logic             idle, full, nonempty;
  logic             start_sq, start_cm, alloc_fire, pop, drop;

  assign idle     = (op_q == OP_IDLE);
  assign nonempty = (used_q != '0);
  assign tail_nxt = IW'(wrap_inc(32'(tail), DEPTH));
  assign tail_prv = IW'(wrap_dec(32'(tail), DEPTH));
  assign full     = (tail_nxt == head);

  assign start_sq   = idle && squash_valid_i;
  assign start_cm   = idle && commit_valid_i && !squash_valid_i;
  assign alloc_ready_o = idle && !full && !squash_valid_i && !commit_valid_i;
  assign alloc_fire = alloc_valid_i && alloc_ready_o;

  assign pop  = (op_q == OP_COMMIT) && nonempty && (seq_head <= bound_q);
  assign drop = (op_q == OP_SQUASH) && nonempty && (seq_last > bound_q);

  lq_ptr #(.DEPTH(DEPTH), .IW(IW)) u_head (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .inc_i (pop),   .dec_i (1'b0),
    .ptr_o (head)
  );

  lq_ptr #(.DEPTH(DEPTH), .IW(IW)) u_tail (
    .clk_i (clk_i),      .rst_ni(rst_ni),
    .inc_i (alloc_fire), .dec_i (drop),
    .ptr_o (tail)
  );

  lq_slots #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQI_W(SQIW), .IW(IW)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (alloc_fire),
    .waddr_i    (tail),
    .wseq_i     (alloc_seq_i),
    .wsq_vld_i  (sq_used_i != '0),
    .wsq_idx_i  (sq_tail_i),
    .raddr_h_i  (head),
    .raddr_t_i  (tail_prv),
    .seq_h_o    (seq_head),
    .sq_vld_h_o (head_sq_vld_o),
    .sq_idx_h_o (head_sq_idx_o),
    .seq_t_o    (seq_last)
  );

  lq_free #(.LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP), .CW(CW), .SQCW(SQCW)) u_free (
    .used_i    (used_q),
    .sq_used_i (sq_used_i),
    .free_o    (free_o)
  );

  // walk state: one entry per clock until the bound stops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IDLE;
      bound_q <= '0;
    end else begin
      unique case (op_q)
        OP_IDLE: begin
          if (start_sq) begin
            op_q    <= OP_SQUASH;
            bound_q <= squash_seq_i;
          end else if (start_cm) begin
            op_q    <= OP_COMMIT;
            bound_q <= commit_seq_i;
          end
        end
        OP_COMMIT: if (!pop)  op_q <= OP_IDLE;
        OP_SQUASH: if (!drop) op_q <= OP_IDLE;
        default:              op_q <= OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              used_q <= '0;
    else if (alloc_fire)      used_q <= used_q + CW'(1);
    else if (pop || drop)     used_q <= used_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q     <= 1'b0;
      blk_seq_q <= '0;
    end else if (blk_set_i) begin
      blk_q     <= 1'b1;
      blk_seq_q <= blk_seq_i;
    end else if (start_sq && blk_q && (squash_seq_i < blk_seq_q)) begin
      blk_q     <= 1'b0;
    end
  end

  assign alloc_idx_o  = tail;
  assign busy_o       = !idle;
  assign blk_o        = blk_q;
  assign head_valid_o = nonempty;
  assign head_seq_o   = seq_head;
  assign count_o      = used_q;
endmodule

// File: rtl/load_queue_chk.sv
module load_queue_chk #(
  parameter int LQ_CAP = 6,
  parameter int SEQ_W  = 16,
  parameter int DEPTH  = LQ_CAP + 1,
  parameter int IW     = $clog2(DEPTH),
  parameter int CW     = $clog2(LQ_CAP + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IW-1:0]    head_i,
  input logic [IW-1:0]    tail_i,
  input logic [CW-1:0]    used_i,
  input logic             busy_i,
  input logic             alloc_ready_i,
  input logic             squash_valid_i,
  input logic [SEQ_W-1:0] squash_seq_i,
  input logic             blk_set_i,
  input logic             blk_i,
  input logic [SEQ_W-1:0] blk_seq_i,
  input logic [CW-1:0]    free_i
);
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(used_i) <= LQ_CAP);

  a_r2_full_refuses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(used_i) == LQ_CAP) |-> !alloc_ready_i);

  a_r9_ptr_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(used_i) == (int'(tail_i) + DEPTH - int'(head_i)) % DEPTH);

  a_r4_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (int'(used_i) == int'($past(used_i)) ||
              int'(used_i) == int'($past(used_i)) + 1 ||
              int'(used_i) + 1 == int'($past(used_i))));

  a_r6_busy_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !alloc_ready_i);

  a_r6_busy_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> int'(used_i) <= int'($past(used_i)));

  a_r7_blk_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_valid_i && !busy_i && blk_i && !blk_set_i && squash_seq_i < blk_seq_i)
      |=> !blk_i);

  a_r8_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_i) + int'(used_i) <= LQ_CAP);
endmodule

bind load_queue load_queue_chk #(
  .LQ_CAP(LQ_CAP), .SEQ_W(SEQ_W), .DEPTH(DEPTH), .IW(IW), .CW(CW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .head_i         (head),
  .tail_i         (tail),
  .used_i         (used_q),
  .busy_i         (busy_o),
  .alloc_ready_i  (alloc_ready_o),
  .squash_valid_i (squash_valid_i),
  .squash_seq_i   (squash_seq_i),
  .blk_set_i      (blk_set_i),
  .blk_i          (blk_q),
  .blk_seq_i      (blk_seq_q),
  .free_i         (free_o)
);

// File: tb/load_queue_tb.sv
`timescale 1ns/1ps
module load_queue_tb_top;
  localparam int LQ_CAP = 6;
  localparam int SQ_CAP = 4;
  localparam int DEPTH  = LQ_CAP + 1;

  typedef struct packed {
    logic [15:0] seq;
    logic [2:0]  sq_used;
    logic [2:0]  sq_tail;
    logic [2:0]  exp_idx;
    logic        exp_vld;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'd10, 3'd0, 3'd1, 3'd0, 1'b0},
    '{16'd20, 3'd2, 3'd3, 3'd1, 1'b1},
    '{16'd30, 3'd1, 3'd0, 3'd2, 1'b1},
    '{16'd40, 3'd3, 3'd2, 3'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        alloc_valid = 0, commit_valid = 0, squash_valid = 0, blk_set = 0;
  logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0, blk_seq = 0;
  logic [2:0]  sq_used = 0, sq_tail = 0;
  logic        alloc_ready, busy, blk, head_valid, head_sq_vld;
  logic [2:0]  alloc_idx, head_sq_idx, count, free;
  logic [15:0] head_seq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  load_queue #(.LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP), .SEQ_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid), .alloc_seq_i(alloc_seq),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .sq_used_i(sq_used), .sq_tail_i(sq_tail),
    .commit_valid_i(commit_valid), .commit_seq_i(commit_seq),
    .squash_valid_i(squash_valid), .squash_seq_i(squash_seq),
    .busy_o(busy), .blk_set_i(blk_set), .blk_seq_i(blk_seq), .blk_o(blk),
    .head_valid_o(head_valid), .head_seq_o(head_seq),
    .head_sq_vld_o(head_sq_vld), .head_sq_idx_o(head_sq_idx),
    .count_o(count), .free_o(free)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input logic [15:0] s);
    alloc_valid = 1; alloc_seq = s;
    step();
    alloc_valid = 0;
  endtask

  // issue command on one edge, return number of busy samples after it
  task automatic run_cmd(input bit sq, input bit cm, input logic [15:0] b, output int n);
    squash_valid = sq; squash_seq = b;
    commit_valid = cm; commit_seq = b;
    step();
    squash_valid = 0; commit_valid = 0;
    n = 0;
    while (busy && n < 40) begin
      n++;
      step();
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    step();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 head_valid", head_valid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 blk", blk, 0);
    chk("R1 ready", alloc_ready, 1);
    chk("R1 idx", alloc_idx, 0);
    chk("R8 free reset", free, 4);

    // vector walk: R2/R3 allocation and recorded store index
    for (int i = 0; i < 4; i++) begin
      sq_used = VECS[i].sq_used; sq_tail = VECS[i].sq_tail;
      chk("R2 alloc idx", alloc_idx, int'(VECS[i].exp_idx));
      alloc(VECS[i].seq);
      chk("R2 count", count, i + 1);
    end
    sq_used = 0; #1;
    chk("R8 free lq-limited", free, 2);
    sq_used = 4; #1;
    chk("R8 free sq-limited", free, 0);
    sq_used = 0; #1;
    chk("R3 head seq", head_seq, 10);
    chk("R3 head invalid sq", head_sq_vld, 0);

    // R4 commit bound 25 pops 10,20
    run_cmd(0, 1, 16'd25, n);
    chk("R4 busy cycles", n, 3);
    chk("R4 count", count, 2);
    chk("R3 head seq after commit", head_seq, 30);
    chk("R3 head sq vld", head_sq_vld, 1);
    chk("R3 head sq idx", head_sq_idx, 0);

    // R5 squash bound 30 drops 40; R6 commit while busy ignored
    squash_valid = 1; squash_seq = 30;
    step();
    squash_valid = 0;
    chk("R6 busy blocks ready", alloc_ready, 0);
    commit_valid = 1; commit_seq = 100;
    step();
    commit_valid = 0;
    n = 0;
    while (busy && n < 40) begin n++; step(); end
    chk("R5 squash count", count, 1);
    chk("R6 ignored commit", head_seq, 30);
    chk("R5 tail back", alloc_idx, 3);

    // R2/R9 fill to full with wrap
    for (int i = 0; i < 5; i++) begin
      chk("R9 wrap idx", alloc_idx, (3 + i) % DEPTH);
      alloc(16'(50 + 10 * i));
    end
    chk("R2 full count", count, 6);
    chk("R2 full ready", alloc_ready, 0);
    chk("R8 free full", free, 0);
    alloc(16'd99);
    chk("R2 refused alloc", count, 6);

    // R5/R9 squash bound 60 drops 90,80,70 across wrap
    run_cmd(1, 0, 16'd60, n);
    chk("R5 busy cycles", n, 4);
    chk("R5 count", count, 3);
    chk("R9 tail wrap back", alloc_idx, 5);

    // R7 blocked flag
    blk_set = 1; blk_seq = 100;
    step();
    blk_set = 0;
    chk("R7 set", blk, 1);
    run_cmd(1, 0, 16'd200, n);
    chk("R7 kept", blk, 1);
    chk("R5 none younger", n, 1);
    chk("R5 none removed", count, 3);
    run_cmd(1, 0, 16'd55, n);
    chk("R7 cleared", blk, 0);
    chk("R5 drop 60", count, 2);

    // R6 same-cycle squash and commit: squash only
    squash_valid = 1; commit_valid = 1; #1;
    chk("R6 ready low on cmd", alloc_ready, 0);
    squash_valid = 0; commit_valid = 0;
    run_cmd(1, 1, 16'd1000, n);
    chk("R6 squash priority", count, 2);

    // R4 commit all to empty
    run_cmd(0, 1, 16'd1000, n);
    chk("R4 commit all busy", n, 3);
    chk("R4 empty", count, 0);
    chk("R4 head_valid", head_valid, 0);
    run_cmd(1, 0, 16'd0, n);
    chk("R5 empty squash", n, 1);
    chk("R5 empty count", count, 0);

    finish_up();
  end
endmodule